// File: doc/BRIEF.md
# MDIO Management Register Slave

This block is the station-management end of a two-wire serial link, as found on a PHY or a small switch. A master drives the management clock and a bidirectional data line. The block watches both, finds read and write frames aimed at the 5-bit station address set by a strap input, and serves a sparse bank of eight 16-bit registers. When it answers a read it drives the data line through an output-enable, so a pad-level tri-state buffer can be built around it.

The block runs on a fast system clock with a synchronous active-high reset. It brings the management clock and data line into that domain through synchronizer chains and reacts once per rising management-clock edge. Register contents are exported as a flat bus toward the core. A write lands in a register only after the last data bit of a valid frame. A read of an address outside the map returns zeros.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: During and right after reset the output enable is low and each register slot i holds RST_BASE + i. Slot i appears on `regs_o[16*i+15:16*i]`. Slots 0..5 hold register addresses 0..5, slot 6 holds address 29 and slot 7 holds address 31.
- R2: A write frame updates the addressed slot with the 16 data bits (MSB first). The update becomes visible only after the rising edge that samples the last data bit, never earlier, and leaves all other slots unchanged. A write frame is 32 ones, start bits 0 then 1, opcode bits 0 then 1, the matching station address and an implemented register address (each 5 bits, MSB first), two turnaround bits, then the data.
- R3: For a read frame (opcode bits 1 then 0), the slave leaves the line undriven for the first turnaround bit and drives 0 for the second. It then drives the 16 register bits MSB first. Each value changes after a rising MDC edge so it is stable at the next one.
- R4: The output enable drops after the rising edge that samples the last read data bit. It is high only for the second turnaround bit and the data bits of a matched read, 17 bit periods at most.
- R5: Register addresses 6..28 and 30 are unimplemented. A read of one is answered with 0x0000. A write to one changes no slot.
- R6: When the frame's station address differs from `phy_addr_i`, the slave never raises the output enable and a write is discarded.
- R7: A frame preceded by fewer than 32 consecutive ones is ignored, for reads and writes alike.
- R8: Start bits other than 0 then 1, or an opcode of 00 or 11, abort the frame with no effect. The next frame with a full preamble is served normally.
- R9: Addresses 29 and 31 reach two separate slots (6 and 7). Writing one does not change the other.
- R10: A preamble longer than 32 ones is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than MDC |
| rst | input | 1 | Synchronous active-high reset |
| mdc_i | input | 1 | Management clock from the master |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven during reads |
| mdio_oe | output | 1 | Output enable for the data line pad |
| phy_addr_i | input | 5 | Strapped station address |
| regs_o | output | 128 | Register slots toward the core, slot i at bits 16i+15..16i |

## Verification
The assertions assume that MDC stays high and low for at least a few system clocks each, so that only one edge pulse falls inside any read-load window. They also assume the master changes MDIO only while MDC is low and that the strap is static. The turnaround, enable-length and write-commit properties rest on those assumptions. The bench holds each MDC phase for four system clocks and changes MDIO only at the start of the low phase. It keeps the strap fixed and starts every frame with a 0 bit so that leftover ones from an aborted frame cannot count toward the next preamble.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int REG_AW = 5;
  localparam int SLOT_N = 8;
  localparam int SLOT_W = $clog2(SLOT_N);

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SOF,
    ST_OPC,
    ST_PHY,
    ST_REG,
    ST_TURN,
    ST_DATA
  } mdio_st_e;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] idx;
  } slot_t;

  // Sparse map: 0..5 direct, 29 -> slot 6, 31 -> slot 7
  function automatic slot_t map_addr(input logic [REG_AW-1:0] a);
    slot_t r;
    r.hit = 1'b1;
    r.idx = '0;
    if (a <= REG_AW'(5))
      r.idx = a[SLOT_W-1:0];
    else if (a == REG_AW'(29))
      r.idx = SLOT_W'(6);
    else if (a == REG_AW'(31))
      r.idx = SLOT_W'(7);
    else
      r.hit = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic bit_vld,
  output logic bit_val
);

  logic [SYNC_N:0]   mdc_q;
  logic [SYNC_N-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q <= '0;
      dat_q <= '1;
    end else begin
      mdc_q <= {mdc_q[SYNC_N-1:0], mdc_i};
      dat_q <= {dat_q[SYNC_N-2:0], mdio_i};
    end
  end

  assign bit_vld = mdc_q[SYNC_N-1] & ~mdc_q[SYNC_N];
  assign bit_val = dat_q[SYNC_N-1];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic [REG_AW-1:0] strap_i,
  output logic              rd_go,
  output logic              wr_en,
  output logic [SLOT_W-1:0] slot_q,
  output logic              slot_hit,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_window
);

  localparam int PC_W  = $clog2(PRE_LEN + 1);
  localparam int CNT_W = $clog2(DATA_W);

  mdio_st_e          st;
  logic [PC_W-1:0]   pre_cnt;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sr;
  logic              op_rd;
  logic              op_wr;
  logic              phy_hit;
  logic [REG_AW-1:0] addr_nx;
  logic [DATA_W-1:0] data_nx;
  slot_t             map_nx;

  assign addr_nx = {sr[REG_AW-2:0], bit_val};
  assign data_nx = {sr[DATA_W-2:0], bit_val};
  assign map_nx  = map_addr(addr_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HUNT;
      pre_cnt  <= '0;
      cnt      <= '0;
      sr       <= '0;
      op_rd    <= 1'b0;
      op_wr    <= 1'b0;
      phy_hit  <= 1'b0;
      slot_q   <= '0;
      slot_hit <= 1'b0;
      rd_go    <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
    end else begin
      rd_go <= 1'b0;
      wr_en <= 1'b0;
      if (bit_vld) begin
        case (st)
          ST_HUNT: begin
            if (bit_val) begin
              if (pre_cnt != PC_W'(PRE_LEN))
                pre_cnt <= pre_cnt + 1'b1;
            end else begin
              if (pre_cnt == PC_W'(PRE_LEN))
                st <= ST_SOF;
              pre_cnt <= '0;
            end
          end
          ST_SOF: begin
            cnt <= '0;
            st  <= bit_val ? ST_OPC : ST_HUNT;
          end
          ST_OPC: begin
            sr  <= data_nx;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(1)) begin
              cnt <= '0;
              case ({sr[0], bit_val})
                2'b10: begin op_rd <= 1'b1; op_wr <= 1'b0; st <= ST_PHY; end
                2'b01: begin op_rd <= 1'b0; op_wr <= 1'b1; st <= ST_PHY; end
                default: st <= ST_HUNT;
              endcase
            end
          end
          ST_PHY: begin
            sr  <= data_nx;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(REG_AW - 1)) begin
              cnt     <= '0;
              phy_hit <= (addr_nx == strap_i);
              st      <= ST_REG;
            end
          end
          ST_REG: begin
            sr  <= data_nx;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(REG_AW - 1)) begin
              cnt      <= '0;
              slot_q   <= map_nx.idx;
              slot_hit <= map_nx.hit;
              rd_go    <= op_rd & phy_hit;
              st       <= ST_TURN;
            end
          end
          ST_TURN: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(1)) begin
              cnt <= '0;
              st  <= ST_DATA;
            end
          end
          ST_DATA: begin
            sr  <= data_nx;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(DATA_W - 1)) begin
              cnt     <= '0;
              wr_en   <= op_wr & phy_hit & slot_hit;
              wr_data <= data_nx;
              pre_cnt <= '0;
              st      <= ST_HUNT;
            end
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

  assign rd_window = ((st == ST_TURN) || (st == ST_DATA)) && op_rd && phy_hit;

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] RST_BASE = 'hA5A0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [SLOT_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [SLOT_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic [SLOT_N*DATA_W-1:0] regs_o
);

  logic [DATA_W-1:0] mem [SLOT_N];

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOT_N; i++) begin
      if (rst)
        mem[i] <= RST_BASE + DATA_W'(i);
      else if (wr_en && (wr_idx == SLOT_W'(i)))
        mem[i] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

  for (genvar g = 0; g < SLOT_N; g++) begin : g_out
    assign regs_o[g*DATA_W +: DATA_W] = mem[g];
  end

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam int RW = $clog2(DATA_W + 2);

  logic [DATA_W:0] sh;
  logic [RW-1:0]   rem;
  logic            busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      rem     <= '0;
      busy    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (load) begin
      sh      <= {1'b0, ld_data};
      rem     <= RW'(DATA_W + 1);
      busy    <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (bit_vld && busy) begin
      if (rem != '0) begin
        mdio_oe <= 1'b1;
        mdio_o  <= sh[DATA_W];
        sh      <= {sh[DATA_W-1:0], 1'b0};
        rem     <= rem - 1'b1;
      end else begin
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b0;
        busy    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                PRE_LEN  = 32,
  parameter int                SYNC_N   = 2,
  parameter logic [DATA_W-1:0] RST_BASE = 'hA5A0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mdc_i,
  input  logic                     mdio_i,
  output logic                     mdio_o,
  output logic                     mdio_oe,
  input  logic [REG_AW-1:0]        phy_addr_i,
  output logic [SLOT_N*DATA_W-1:0] regs_o
);

  logic              bit_vld;
  logic              bit_val;
  logic              rd_go;
  logic              wr_en;
  logic [SLOT_W-1:0] slot_q;
  logic              slot_hit;
  logic [DATA_W-1:0] wr_data;
  logic              rd_window;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] ld_data;

  mdio_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .mdc_i   (mdc_i),
    .mdio_i  (mdio_i),
    .bit_vld (bit_vld),
    .bit_val (bit_val)
  );

  mdio_frame_fsm #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .strap_i   (phy_addr_i),
    .rd_go     (rd_go),
    .wr_en     (wr_en),
    .slot_q    (slot_q),
    .slot_hit  (slot_hit),
    .wr_data   (wr_data),
    .rd_window (rd_window)
  );

  mdio_reg_bank #(.DATA_W(DATA_W), .RST_BASE(RST_BASE)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (slot_q),
    .wr_data (wr_data),
    .rd_idx  (slot_q),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );

  assign ld_data = slot_hit ? rd_data : '0;

  mdio_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (bit_vld),
    .load    (rd_go),
    .ld_data (ld_data),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int DATA_W = 16,
  parameter int REGS_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_vld,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              rd_window,
  input logic              wr_en,
  input logic [REGS_W-1:0] regs_o
);

  localparam int OW = $clog2(DATA_W + 3);

  logic [OW-1:0] oe_bits;

  always_ff @(posedge clk) begin
    if (rst || !mdio_oe)
      oe_bits <= '0;
    else if (bit_vld)
      oe_bits <= oe_bits + 1'b1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !mdio_oe);

  // R3
  ta_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  // R4
  oe_window_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> rd_window);

  // R4
  oe_len_chk: assert property (@(posedge clk) disable iff (rst)
    oe_bits <= OW'(DATA_W + 1));

  // R2
  reg_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(regs_o) |-> $past(wr_en));

endmodule

bind mdio_mgmt_slave mdio_mgmt_chk #(
  .DATA_W (DATA_W),
  .REGS_W (mdio_pkg::SLOT_N * DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_vld   (bit_vld),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .rd_window (rd_window),
  .wr_en     (wr_en),
  .regs_o    (regs_o)
);

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mdc = 1'b0;
  logic         mdio_m = 1'b1;
  logic [4:0]   strap = 5'h0B;
  logic         mdio_o;
  logic         mdio_oe;
  logic [127:0] regs_o;

  int errors = 0;
  int checks = 0;
  logic        s_oe, s_o;
  logic        oe_seen = 1'b0;
  logic [15:0] exp_r [8];

  always #5 clk = ~clk;

  mdio_mgmt_slave u_mdio_mgmt_slave (
    .clk        (clk),
    .rst        (rst),
    .mdc_i      (mdc),
    .mdio_i     (mdio_oe ? mdio_o : mdio_m),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .phy_addr_i (strap),
    .regs_o     (regs_o)
  );

  always @(negedge clk) if (mdio_oe === 1'b1) oe_seen = 1'b1;

  function automatic int slot_of(input logic [4:0] a);
    if (a <= 5'd5) return int'(a);
    if (a == 5'd29) return 6;
    if (a == 5'd31) return 7;
    return -1;
  endfunction

  function automatic logic [127:0] model_pack();
    logic [127:0] p;
    for (int i = 0; i < 8; i++) p[i*16 +: 16] = exp_r[i];
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic v);
    @(negedge clk);
    mdc = 1'b0;
    mdio_m = v;
    repeat (4) @(negedge clk);
    s_oe = mdio_oe;
    s_o  = mdio_o;
    mdc  = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                       output logic [17:0] c_oe, output logic [17:0] c_o,
                       output logic [127:0] regs_before);
    oe_seen = 1'b0;
    bit_x(1'b0);
    for (int i = 0; i < pre; i++) bit_x(1'b1);
    bit_x(st[1]); bit_x(st[0]);
    bit_x(op[1]); bit_x(op[0]);
    for (int i = 4; i >= 0; i--) bit_x(phy[i]);
    for (int i = 4; i >= 0; i--) bit_x(ra[i]);
    for (int k = 0; k < 18; k++) begin
      logic v;
      if (op == 2'b01) v = (k == 0) ? 1'b1 : (k == 1) ? 1'b0 : wd[17-k];
      else v = 1'b1;
      if (k == 17) regs_before = regs_o;
      bit_x(v);
      c_oe[17-k] = s_oe;
      c_o[17-k]  = s_o;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic run_rd(input int pre, input logic [4:0] phy, input logic [4:0] ra, input string req);
    logic [17:0] c_oe, c_o;
    logic [127:0] rb;
    int sl;
    logic [15:0] e;
    sl = slot_of(ra);
    e = (sl < 0) ? 16'h0000 : exp_r[sl];
    frame(pre, 2'b01, 2'b10, phy, ra, 16'h0, c_oe, c_o, rb);
    if (pre >= 32 && phy == strap) begin
      chk(c_oe == 18'h1FFFF, {req, " R3 enable pattern"}, 128'(c_oe), 128'(18'h1FFFF));
      chk(c_o[16] == 1'b0, {req, " R3 turnaround zero"}, 128'(c_o[16]), 128'(0));
      chk(c_o[15:0] == e, {req, " R3 read data"}, 128'(c_o[15:0]), 128'(e));
      chk(mdio_oe == 1'b0, {req, " R4 release"}, 128'(mdio_oe), 128'(0));
    end else begin
      chk(oe_seen == 1'b0, {req, " never driven"}, 128'(oe_seen), 128'(0));
    end
  endtask

  task automatic run_wr(input int pre, input logic [1:0] st, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                        input string req);
    logic [17:0] c_oe, c_o;
    logic [127:0] rb, old;
    int sl;
    old = model_pack();
    sl = slot_of(ra);
    frame(pre, st, op, phy, ra, wd, c_oe, c_o, rb);
    chk(rb == old, {req, " R2 no early update"}, rb, old);
    if (pre >= 32 && st == 2'b01 && op == 2'b01 && phy == strap && sl >= 0) exp_r[sl] = wd;
    chk(regs_o == model_pack(), {req, " register bus"}, regs_o, model_pack());
    chk(oe_seen == 1'b0, {req, " R4 no drive on write"}, 128'(oe_seen), 128'(0));
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) exp_r[i] = 16'hA5A0 + 16'(i);
    chk(mdio_oe == 1'b0, "R1 enable low", 128'(mdio_oe), 128'(0));
    chk(regs_o == model_pack(), "R1 reset values", regs_o, model_pack());
  endtask

  task automatic t_basic_read();
    run_rd(32, strap, 5'd0, "R3 addr0");
    run_rd(32, strap, 5'd31, "R3 addr31");
    run_rd(32, strap, 5'd5, "R3 addr5");
  endtask

  task automatic t_write();
    run_wr(32, 2'b01, 2'b01, strap, 5'd3, 16'h3C5A, "R2 addr3");
    run_rd(32, strap, 5'd3, "R2 readback");
    run_wr(32, 2'b01, 2'b01, strap, 5'd0, 16'h8001, "R2 addr0");
  endtask

  task automatic t_sparse();
    run_wr(32, 2'b01, 2'b01, strap, 5'd29, 16'h1D29, "R9 addr29");
    run_wr(32, 2'b01, 2'b01, strap, 5'd31, 16'hF31F, "R9 addr31");
    chk(regs_o[111:96] == 16'h1D29, "R9 slot6 kept", 128'(regs_o[111:96]), 128'(16'h1D29));
    run_rd(32, strap, 5'd29, "R9 read29");
    run_rd(32, strap, 5'd30, "R5 read30");
  endtask

  task automatic t_unimpl();
    run_wr(32, 2'b01, 2'b01, strap, 5'd7, 16'hFFFF, "R5 write7");
    run_wr(32, 2'b01, 2'b01, strap, 5'd30, 16'h0F0F, "R5 write30");
    run_rd(32, strap, 5'd7, "R5 read7");
  endtask

  task automatic t_mismatch();
    run_rd(32, strap ^ 5'h01, 5'd3, "R6 read");
    run_wr(32, 2'b01, 2'b01, strap ^ 5'h10, 5'd3, 16'h0000, "R6 write");
  endtask

  task automatic t_short();
    run_wr(31, 2'b01, 2'b01, strap, 5'd1, 16'h1234, "R7 write");
    run_rd(31, strap, 5'd1, "R7 read");
  endtask

  task automatic t_abort();
    run_wr(32, 2'b00, 2'b01, strap, 5'd2, 16'hBEEF, "R8 bad start");
    run_wr(32, 2'b01, 2'b11, strap, 5'd2, 16'hBEEF, "R8 opcode11");
    run_wr(32, 2'b01, 2'b00, strap, 5'd2, 16'hBEEF, "R8 opcode00");
    run_rd(32, strap, 5'd2, "R8 recover");
  endtask

  task automatic t_long();
    run_wr(40, 2'b01, 2'b01, strap, 5'd4, 16'h4A4A, "R10 write");
    run_rd(45, strap, 5'd4, "R10 read");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic_read();
    t_write();
    t_sparse();
    t_unimpl();
    t_mismatch();
    t_short();
    t_abort();
    t_long();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule